// File: doc/BRIEF.md
# Flash Command Sequencer with Embedded Program and Erase

This block sits on the device side of a byte-wide NOR-style flash array. It watches the host's write-bus cycles and looks for the unlock handshake that must come before any change to the array. It then runs one of three embedded operations on the array: a single-byte program, a whole-array erase, or an erase of a chosen set of sectors. The array is outside the block. The block drives it through three strobes: a byte write, a sector clear-to-zero and a sector set-to-one. It reads the current byte back through a separate data input.

During a sector erase, the host may queue more sectors for a limited time. Each accepted sector command restarts that acceptance window. When the window expires, the erase starts. From then on every write is dropped until the operation ends. Each erase first drives every selected sector to all zeros, waits a modelled erase time, and only then sets those sectors to all ones. A hardware reset ends any operation at once.

The host tracks progress through a busy flag and a status byte that it samples on read strobes.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A byte program is the four writes (0x555,0xAA), (0x2AA,0x55), (0x555,0xA0), then (target address, data). The array byte then holds the bitwise AND of its old value and the data, and `busy` is 1 until the operation completes. Unlock addresses are compared on address bits [11:0].
- R2: Programming can only clear bits. If the data has a 1 where the stored byte has a 0, that bit stays 0 and status bit 5 becomes 1. Status bit 5 returns to 0 when the next program or erase is launched.
- R3: Chip erase is (0x555,0xAA), (0x2AA,0x55), (0x555,0x80), (0x555,0xAA), (0x2AA,0x55), (0x555,0x10). Afterwards every array byte reads 0xFF.
- R4: Sector erase uses the same first five writes as chip erase. The sixth write carries data 0x30, and its top log2(NSECT) address bits select the sector. Only the selected sectors become 0xFF.
- R5: After an accepted sector command, another write with data 0x30 adds its sector if it is sampled within WIN_CYC clock edges. Each accepted add restarts the count. If no add arrives by the WIN_CYC-th edge, the erase starts on that edge.
- R6: Once the erase has started, every write is ignored until `busy` falls. This includes a late sector command, whose sector is left unchanged.
- R7: A write that does not match the expected next cycle of a sequence returns the decoder to read mode. A later lone data write then changes nothing.
- R8: When `rst_n` is low, the current operation is abandoned. `busy` and the status byte go to 0, and the decoder returns to read mode.
- R9: An erase drives every selected sector to 0x00 before any sector is set to 0xFF. A reset during the erase wait therefore leaves those sectors at 0x00.
- R10: While busy, status bit 7 is the inverse of bit 7 of the byte being programmed, and it is 0 during an erase. Status bit 6 flips on every `rd_en` cycle. Status bit 3 is 1 from erase start until completion. When idle, bits 7, 6 and 3 are 0.
- R11: A completed erase clears its sector selection, so the next sector erase touches only the sectors it names itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| wr_en | input | 1 | Host write strobe, one cycle per bus write |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | 8 | Host write data |
| rd_en | input | 1 | Host status read strobe |
| busy | output | 1 | Operation or sector window in progress |
| poll | output | 8 | Status byte: bit 7 data poll, 6 toggle, 5 program error, 3 erase running |
| arr_addr | output | ADDR_W | Array byte address for program |
| arr_rdata | input | 8 | Array byte currently at `arr_addr` |
| arr_wdata | output | 8 | Byte to store on `arr_pgm` |
| arr_pgm | output | 1 | Byte write strobe |
| arr_sec | output | log2(NSECT) | Sector index for the sector strobes |
| arr_sec_zero | output | 1 | Clear the sector `arr_sec` to 0x00 |
| arr_sec_one | output | 1 | Set the sector `arr_sec` to 0xFF |

## Verification
Most internal faults here first appear in the array contents, so the bench keeps its own model of the array and compares every byte it may have touched as soon as `busy` falls. A decoder stuck past its read state shows on the next lone data write, which then alters a byte that should stay the same. A window counter that is off by one shows only at the exact edges WIN_CYC-2 and WIN_CYC-1 of inter-command gap, so both gaps are driven. A sector mask that is not released shows one erase later, as damage to sectors that had been reprogrammed in between.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   typedef enum logic [2:0] {
      D_READ, D_UL1, D_UL2, D_SETUP, D_UL4, D_UL5, D_PGM
   } dec_st_t;

   typedef enum logic [2:0] {
      Q_IDLE, Q_PROG, Q_PWAIT, Q_PRE, Q_EWAIT, Q_ERS
   } seq_st_t;

   localparam logic [11:0] KEY_A1  = 12'h555;
   localparam logic [11:0] KEY_A2  = 12'h2AA;
   localparam logic [7:0]  KEY_D1  = 8'hAA;
   localparam logic [7:0]  KEY_D2  = 8'h55;
   localparam logic [7:0]  OP_SETUP = 8'h80;
   localparam logic [7:0]  OP_CHIP  = 8'h10;
   localparam logic [7:0]  OP_SECT  = 8'h30;
   localparam logic [7:0]  OP_PROG  = 8'hA0;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        data,
   output logic              cmd_prog,
   output logic              cmd_chip,
   output logic              cmd_sect
);

   dec_st_t     st_q, st_d;
   logic [11:0] lo;
   logic        hit1, hit2;

   assign lo   = addr[11:0];
   assign hit1 = (lo == KEY_A1) && (data == KEY_D1);
   assign hit2 = (lo == KEY_A2) && (data == KEY_D2);

   always_comb begin
      st_d     = st_q;
      cmd_prog = 1'b0;
      cmd_chip = 1'b0;
      cmd_sect = 1'b0;
      if (wr_en) begin
         case (st_q)
            D_READ:  st_d = hit1 ? D_UL1 : D_READ;
            D_UL1:   st_d = hit2 ? D_UL2 : D_READ;
            D_UL2: begin
               if ((lo == KEY_A1) && (data == OP_SETUP))     st_d = D_SETUP;
               else if ((lo == KEY_A1) && (data == OP_PROG)) st_d = D_PGM;
               else                                          st_d = D_READ;
            end
            D_SETUP: st_d = hit1 ? D_UL4 : D_READ;
            D_UL4:   st_d = hit2 ? D_UL5 : D_READ;
            D_UL5: begin
               st_d     = D_READ;
               cmd_chip = (lo == KEY_A1) && (data == OP_CHIP);
               cmd_sect = (data == OP_SECT);
            end
            D_PGM: begin
               st_d     = D_READ;
               cmd_prog = 1'b1;
            end
            default: st_d = D_READ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= D_READ;
      else        st_q <= st_d;
   end

endmodule

// File: rtl/flash_sect_buf.sv
module flash_sect_buf #(
   parameter int NSECT   = 4,
   parameter int SEC_W   = 2,
   parameter int WIN_CYC = 50
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             add,
   input  logic [SEC_W-1:0] add_sec,
   output logic             win_open,
   output logic             launch,
   output logic [NSECT-1:0] mask
);

   localparam int CW = $clog2(WIN_CYC + 1);

   logic [CW-1:0] cnt_q;

   assign launch = win_open && !add && (cnt_q == CW'(WIN_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_open <= 1'b0;
         cnt_q    <= '0;
      end else if (add) begin
         win_open <= 1'b1;
         cnt_q    <= '0;
      end else if (launch) begin
         win_open <= 1'b0;
         cnt_q    <= '0;
      end else if (win_open) begin
         cnt_q    <= cnt_q + 1'b1;
      end
   end

   for (genvar g = 0; g < NSECT; g++) begin : g_sel
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                      mask[g] <= 1'b0;
         else if (add && (add_sec == SEC_W'(g)))          mask[g] <= 1'b1;
         else if (launch)                                 mask[g] <= 1'b0;
      end
   end

endmodule

// File: rtl/flash_embed_seq.sv
module flash_embed_seq
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int NSECT     = 4,
   parameter int SEC_W     = 2,
   parameter int PROG_CYC  = 4,
   parameter int ERASE_CYC = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_prog,
   input  logic [ADDR_W-1:0] p_addr,
   input  logic [7:0]        p_data,
   input  logic              go_erase,
   input  logic [NSECT-1:0]  e_mask,
   input  logic              win_open,
   input  logic              rd_en,
   input  logic [7:0]        arr_rdata,
   output logic              seq_busy,
   output logic [7:0]        poll,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [7:0]        arr_wdata,
   output logic              arr_pgm,
   output logic [SEC_W-1:0]  arr_sec,
   output logic              arr_sec_zero,
   output logic              arr_sec_one
);

   localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
   localparam int TW   = $clog2(MAXC + 1);
   localparam logic [SEC_W-1:0] LAST = SEC_W'(NSECT - 1);

   seq_st_t           st_q;
   logic [TW-1:0]     cnt_q;
   logic [SEC_W-1:0]  idx_q;
   logic [NSECT-1:0]  msk_q;
   logic [ADDR_W-1:0] a_q;
   logic [7:0]        d_q;
   logic              err_q, tog_q;
   logic              act, erasing;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= Q_IDLE;
         cnt_q <= '0;
         idx_q <= '0;
         msk_q <= '0;
         a_q   <= '0;
         d_q   <= 8'hFF;
         err_q <= 1'b0;
      end else begin
         case (st_q)
            Q_IDLE: begin
               if (go_prog) begin
                  st_q  <= Q_PROG;
                  a_q   <= p_addr;
                  d_q   <= p_data;
                  err_q <= 1'b0;
               end else if (go_erase) begin
                  st_q  <= Q_PRE;
                  msk_q <= e_mask;
                  idx_q <= '0;
                  d_q   <= 8'hFF;
                  err_q <= 1'b0;
               end
            end
            Q_PROG: begin
               err_q <= |(d_q & ~arr_rdata);
               cnt_q <= '0;
               st_q  <= Q_PWAIT;
            end
            Q_PWAIT: begin
               if (cnt_q == TW'(PROG_CYC - 1)) st_q <= Q_IDLE;
               else                            cnt_q <= cnt_q + 1'b1;
            end
            Q_PRE: begin
               if (idx_q == LAST) begin
                  st_q  <= Q_EWAIT;
                  cnt_q <= '0;
                  idx_q <= '0;
               end else idx_q <= idx_q + 1'b1;
            end
            Q_EWAIT: begin
               if (cnt_q == TW'(ERASE_CYC - 1)) st_q <= Q_ERS;
               else                             cnt_q <= cnt_q + 1'b1;
            end
            Q_ERS: begin
               if (idx_q == LAST) begin
                  st_q  <= Q_IDLE;
                  msk_q <= '0;
                  idx_q <= '0;
               end else idx_q <= idx_q + 1'b1;
            end
            default: st_q <= Q_IDLE;
         endcase
      end
   end

   assign seq_busy = (st_q != Q_IDLE);
   assign act      = seq_busy || win_open;
   assign erasing  = (st_q == Q_PRE) || (st_q == Q_EWAIT) || (st_q == Q_ERS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            tog_q <= 1'b0;
      else if (!act)         tog_q <= 1'b0;
      else if (rd_en)        tog_q <= ~tog_q;
   end

   always_comb begin
      poll    = '0;
      poll[7] = ((st_q == Q_PROG) || (st_q == Q_PWAIT)) ? ~d_q[7] : 1'b0;
      poll[6] = act & tog_q;
      poll[5] = err_q;
      poll[3] = erasing;
   end

   assign arr_addr     = a_q;
   assign arr_wdata    = d_q & arr_rdata;
   assign arr_pgm      = (st_q == Q_PROG);
   assign arr_sec      = idx_q;
   assign arr_sec_zero = (st_q == Q_PRE) && msk_q[idx_q];
   assign arr_sec_one  = (st_q == Q_ERS) && msk_q[idx_q];

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int NSECT     = 4,
   parameter int WIN_CYC   = 50,
   parameter int PROG_CYC  = 4,
   parameter int ERASE_CYC = 20,
   localparam int SEC_W    = $clog2(NSECT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              rd_en,
   output logic              busy,
   output logic [7:0]        poll,
   output logic [ADDR_W-1:0] arr_addr,
   input  logic [7:0]        arr_rdata,
   output logic [7:0]        arr_wdata,
   output logic              arr_pgm,
   output logic [SEC_W-1:0]  arr_sec,
   output logic              arr_sec_zero,
   output logic              arr_sec_one
);

   if (ADDR_W < 12)                  begin : g_chk_aw  $error("ADDR_W must cover the unlock keys"); end
   if (NSECT < 2 || (1 << SEC_W) != NSECT) begin : g_chk_ns $error("NSECT must be a power of two"); end
   if (WIN_CYC < 2 || PROG_CYC < 1 || ERASE_CYC < 1) begin : g_chk_cy $error("cycle counts too small"); end

   logic             cmd_prog, cmd_chip, cmd_sect;
   logic             win_open, launch, seq_busy, add_more, sect_add;
   logic [NSECT-1:0] buf_mask;

   assign busy     = seq_busy | win_open;
   assign add_more = wr_en && win_open && !seq_busy && (wr_data == OP_SECT);
   assign sect_add = cmd_sect | add_more;

   flash_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en & ~busy),
      .addr(wr_addr), .data(wr_data),
      .cmd_prog(cmd_prog), .cmd_chip(cmd_chip), .cmd_sect(cmd_sect)
   );

   flash_sect_buf #(.NSECT(NSECT), .SEC_W(SEC_W), .WIN_CYC(WIN_CYC)) u_buf (
      .clk(clk), .rst_n(rst_n), .add(sect_add),
      .add_sec(wr_addr[ADDR_W-1 -: SEC_W]),
      .win_open(win_open), .launch(launch), .mask(buf_mask)
   );

   flash_embed_seq #(
      .ADDR_W(ADDR_W), .NSECT(NSECT), .SEC_W(SEC_W),
      .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .go_prog(cmd_prog), .p_addr(wr_addr), .p_data(wr_data),
      .go_erase(launch | cmd_chip),
      .e_mask(cmd_chip ? {NSECT{1'b1}} : buf_mask),
      .win_open(win_open), .rd_en(rd_en), .arr_rdata(arr_rdata),
      .seq_busy(seq_busy), .poll(poll),
      .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_pgm(arr_pgm),
      .arr_sec(arr_sec), .arr_sec_zero(arr_sec_zero), .arr_sec_one(arr_sec_one)
   );

endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk #(
   parameter int ADDR_W = 12
) (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic       rd_en,
   input logic       busy,
   input logic [7:0] poll,
   input logic [7:0] arr_rdata,
   input logic [7:0] arr_wdata,
   input logic       arr_pgm,
   input logic       arr_sec_zero,
   input logic       arr_sec_one
);

   AST_PGM_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      arr_pgm |-> $past(wr_en)); // R1

   AST_PGM_CLEARS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      arr_pgm |-> ((arr_wdata & ~arr_rdata) == 8'h00)); // R2

   AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(arr_pgm || arr_sec_zero || arr_sec_one)); // R6

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({arr_pgm, arr_sec_zero, arr_sec_one})); // R9

   AST_SECT_IN_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_sec_zero || arr_sec_one) |-> poll[3]); // R9

   AST_TOGGLE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rd_en) |=> (!busy || (poll[6] != $past(poll[6])))); // R10

   AST_ERASE_FLAG_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      poll[3] |-> busy); // R10

endmodule

bind flash_cmd_ctrl flash_cmd_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .busy(busy),
   .poll(poll), .arr_rdata(arr_rdata), .arr_wdata(arr_wdata),
   .arr_pgm(arr_pgm), .arr_sec_zero(arr_sec_zero), .arr_sec_one(arr_sec_one)
);

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb_top;

   localparam int ADDR_W  = 12;
   localparam int NSECT   = 4;
   localparam int SEC_W   = 2;
   localparam int WIN_CYC = 50;
   localparam int DEPTH   = 1 << ADDR_W;
   localparam int SECSZ   = DEPTH / NSECT;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [7:0]        wr_data = '0;
   logic              rd_en = 1'b0;
   logic              busy;
   logic [7:0]        poll;
   logic [ADDR_W-1:0] arr_addr;
   logic [7:0]        arr_rdata, arr_wdata;
   logic              arr_pgm, arr_sec_zero, arr_sec_one;
   logic [SEC_W-1:0]  arr_sec;
   logic              fill_all = 1'b0;

   logic [7:0] mem [DEPTH];
   logic [7:0] mdl [DEPTH];
   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   flash_cmd_ctrl #(.ADDR_W(ADDR_W), .NSECT(NSECT), .WIN_CYC(WIN_CYC)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .busy(busy), .poll(poll), .arr_addr(arr_addr),
      .arr_rdata(arr_rdata), .arr_wdata(arr_wdata), .arr_pgm(arr_pgm),
      .arr_sec(arr_sec), .arr_sec_zero(arr_sec_zero), .arr_sec_one(arr_sec_one)
   );

   // array model
   assign arr_rdata = mem[arr_addr];
   always @(posedge clk) begin
      if (fill_all) for (int j = 0; j < DEPTH; j++) mem[j] <= 8'hFF;
      if (arr_pgm) mem[arr_addr] <= arr_wdata;
      if (arr_sec_zero) for (int j = 0; j < SECSZ; j++) mem[int'(arr_sec) * SECSZ + j] <= 8'h00;
      if (arr_sec_one)  for (int j = 0; j < SECSZ; j++) mem[int'(arr_sec) * SECSZ + j] <= 8'hFF;
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [ADDR_W-1:0] sec_base(input int s);
      return ADDR_W'(s * SECSZ);
   endfunction

   task automatic mdl_erase(input logic [NSECT-1:0] m, input logic [7:0] v);
      for (int j = 0; j < DEPTH; j++) if (m[j / SECSZ]) mdl[j] = v;
   endtask

   task automatic cmp_all(input string req, input string what);
      int bad = 0;
      int first = -1;
      for (int j = 0; j < DEPTH; j++)
         if (mem[j] !== mdl[j]) begin
            bad++;
            if (first < 0) first = j;
         end
      if (first < 0) chk(1'b1, req, what, 0, 0);
      else chk(1'b0, req, what, int'(mem[first]), int'(mdl[first]));
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic unlock();
      wr(12'h555, 8'hAA);
      wr(12'h2AA, 8'h55);
   endtask

   task automatic wait_idle(input string req);
      int n = 0;
      while (busy && n < 3000) begin @(negedge clk); n++; end
      chk(!busy, req, "operation completes", int'(busy), 0);
   endtask

   task automatic do_prog(input logic [ADDR_W-1:0] a, input logic [7:0] d, input string req);
      logic exp_err;
      exp_err = |(d & ~mdl[a]);
      unlock();
      wr(12'h555, 8'hA0);
      wr(a, d);
      mdl[a] = mdl[a] & d;
      wait_idle(req);
      chk(mem[a] === mdl[a], req, "programmed byte", int'(mem[a]), int'(mdl[a]));
      chk(poll[5] === exp_err, req, "program error bit", int'(poll[5]), int'(exp_err));
   endtask

   task automatic erase_head();
      unlock();
      wr(12'h555, 8'h80);
      unlock();
   endtask

   task automatic wait_erasing();
      int n = 0;
      while (!poll[3] && n < 500) begin @(negedge clk); n++; end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin : stim
      logic [7:0] p6;
      logic [NSECT-1:0] m;
      void'($urandom(32'd4591));
      for (int j = 0; j < DEPTH; j++) mdl[j] = 8'hFF;
      fill_all = 1'b1;
      repeat (2) @(negedge clk);
      fill_all = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      chk(busy === 1'b0, "R8", "busy after reset", int'(busy), 0);
      chk(poll === 8'h00, "R8", "status after reset", int'(poll), 0);

      // directed program with data-poll check
      unlock();
      wr(12'h555, 8'hA0);
      wr(12'h123, 8'h5A);
      mdl[12'h123] = 8'h5A;
      chk(busy === 1'b1, "R1", "busy during program", int'(busy), 1);
      chk(poll[7] === 1'b1, "R10", "data poll bit inverted", int'(poll[7]), 1);
      wait_idle("R1");
      chk(mem[12'h123] === 8'h5A, "R1", "directed program", int'(mem[12'h123]), 8'h5A);
      chk(poll === 8'h00, "R10", "idle status", int'(poll), 0);

      // try to raise bits
      do_prog(12'h123, 8'hF0, "R2");
      do_prog(12'h124, 8'h00, "R2");

      // random programs
      for (int i = 0; i < 40; i++)
         do_prog(ADDR_W'($urandom_range(DEPTH - 1)), 8'($urandom), "R1");

      // broken sequences
      unlock();
      wr(12'h555, 8'h00);
      wr(12'h200, 8'h00);
      repeat (3) @(negedge clk);
      chk(mem[12'h200] === mdl[12'h200], "R7", "aborted sequence", int'(mem[12'h200]), int'(mdl[12'h200]));
      wr(12'h555, 8'hAA);
      wr(12'h2AB, 8'h55);
      wr(12'h555, 8'hA0);
      wr(12'h201, 8'h00);
      repeat (3) @(negedge clk);
      chk(mem[12'h201] === mdl[12'h201] && !busy, "R7", "wrong unlock address", int'(mem[12'h201]), int'(mdl[12'h201]));

      // chip erase with toggle checks
      erase_head();
      wr(12'h555, 8'h10);
      chk(poll[3] === 1'b1, "R10", "erase flag", int'(poll[3]), 1);
      chk(poll[7] === 1'b0, "R10", "erase data poll", int'(poll[7]), 0);
      for (int i = 0; i < 3; i++) begin
         p6 = poll;
         @(negedge clk); rd_en = 1'b1;
         @(negedge clk); rd_en = 1'b0;
         chk(poll[6] !== p6[6], "R10", "toggle on read", int'(poll[6]), int'(!p6[6]));
      end
      wait_idle("R3");
      mdl_erase('1, 8'hFF);
      cmp_all("R3", "chip erase");

      // single sector erase after filling zeros in each sector
      for (int s = 0; s < NSECT; s++) do_prog(sec_base(s) + 12'h11, 8'h00, "R4");
      erase_head();
      wr(sec_base(2) + 12'h7, 8'h30);
      wait_idle("R4");
      mdl_erase(4'b0100, 8'hFF);
      cmp_all("R4", "only sector 2 erased");

      // window boundary accept: gap WIN_CYC-2 idle negedges
      for (int s = 0; s < NSECT; s++) do_prog(sec_base(s) + 12'h22, 8'h0F, "R5");
      erase_head();
      wr(sec_base(0), 8'h30);
      repeat (WIN_CYC - 2) @(negedge clk);
      wr(sec_base(3) + 12'h5, 8'h30);
      wait_idle("R5");
      mdl_erase(4'b1001, 8'hFF);
      cmp_all("R5", "late-edge add accepted");

      // window boundary reject: gap WIN_CYC-1
      for (int s = 0; s < NSECT; s++) do_prog(sec_base(s) + 12'h33, 8'h3C, "R5");
      erase_head();
      wr(sec_base(1), 8'h30);
      repeat (WIN_CYC - 1) @(negedge clk);
      wr(sec_base(2), 8'h30);
      wait_idle("R5");
      mdl_erase(4'b0010, 8'hFF);
      cmp_all("R5", "add after window rejected");

      // writes during erase ignored; released mask afterwards
      erase_head();
      wr(sec_base(3), 8'h30);
      wait_erasing();
      wr(sec_base(0), 8'h30);
      unlock();
      wr(12'h555, 8'hA0);
      wr(12'h050, 8'h00);
      wait_idle("R6");
      mdl_erase(4'b1000, 8'hFF);
      cmp_all("R6", "writes during erase ignored");
      for (int s = 0; s < NSECT; s++) do_prog(sec_base(s) + 12'h44, 8'h00, "R11");
      erase_head();
      wr(sec_base(1), 8'h30);
      wait_idle("R11");
      mdl_erase(4'b0010, 8'hFF);
      cmp_all("R11", "selection released");

      // random multi-sector erases
      for (int r = 0; r < 3; r++) begin
         for (int i = 0; i < 6; i++)
            do_prog(ADDR_W'($urandom_range(DEPTH - 1)), 8'($urandom), "R4");
         m = NSECT'($urandom_range(1, (1 << NSECT) - 1));
         erase_head();
         begin
            bit first = 1'b1;
            for (int s = 0; s < NSECT; s++)
               if (m[s]) begin
                  if (!first) repeat ($urandom_range(0, WIN_CYC - 3)) @(negedge clk);
                  wr(sec_base(s) + ADDR_W'($urandom_range(SECSZ - 1)), 8'h30);
                  first = 1'b0;
               end
         end
         wait_idle("R4");
         mdl_erase(m, 8'hFF);
         cmp_all("R4", "random sector set");
      end

      // reset during erase wait
      for (int s = 0; s < NSECT; s++) do_prog(sec_base(s) + 12'h66, 8'h81, "R9");
      erase_head();
      wr(12'h555, 8'h10);
      repeat (NSECT + 4) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(busy === 1'b0 && poll === 8'h00, "R8", "reset aborts", int'({busy, poll}), 0);
      rst_n = 1'b1;
      mdl_erase('1, 8'h00);
      cmp_all("R9", "preprogrammed zeros remain");
      wr(12'h300, 8'h00);
      repeat (3) @(negedge clk);
      chk(mem[12'h300] === 8'h00 && !busy, "R8", "decoder in read mode", int'(busy), 0);
      do_prog(12'h300, 8'hFF, "R2");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule